// File: doc/BRIEF.md
# Header-Length Packet Assembler with XOR Check

This block sits behind a byte deframer and turns a stream of received bytes into packets. The first byte accepted after reset, after a completed packet, or after a discard is taken as the packet header. A fixed piecewise rule turns that header into the number of message bytes that follow it. A single checksum byte then closes the packet, so a packet holds the message length plus two bytes in all.

When the closing byte arrives, the block raises a one-cycle completion pulse. It also presents the header and the decoded message length, and flags whether the checksum byte equals the XOR of the header and every message byte. The XOR is built up as the bytes arrive, so completion needs no second pass over stored data. Every accepted byte is also written into a small buffer at its position in the packet, where a reader can fetch it at any address through a combinational read port.

Two inputs throw away a partly assembled packet: a framing-loss pulse, and a start-of-packet indication that marks a new preamble. In either case the next accepted byte is a fresh header.

Top module: `pkt_assembler`

## Requirements
- R1: The message length for header h is 1 when h is 0x00..0x1F, and 2 + (h-32)/16 when h is 0x20..0x7F, both using integer division. It is reported on `pkt_len` together with the completion pulse.
- R2: The message length for header h is 8 + (h-128)/8 when h is 0x80..0xDF, and 20 + (h-224)/4 when h is 0xE0..0xFF, both using integer division. The largest length is therefore 27.
- R3: `pkt_done` is high for exactly one cycle, in the cycle after the byte that brings the accepted count to message length + 2. In that same cycle `pkt_hdr` and `pkt_len` show the packet's header and message length, and they hold those values until the next completion.
- R4: `pkt_ok` is 1 when the final byte equals the XOR of the header and all message bytes, and 0 otherwise. It is valid together with `pkt_done` and holds until the next completion.
- R5: The byte accepted right after a completing byte is treated as a new header, so packets may follow each other with no idle cycles between them.
- R6: An `abort` pulse discards the packet in progress. A byte presented in the same cycle as the pulse is also discarded, and the next accepted byte is a header.
- R7: A `sop` pulse discards the packet in progress in the same way as R6. A byte presented in the same cycle is discarded, and the next accepted byte is a header.
- R8: After a completion and before the next accepted byte, `rd_data` at address i returns byte i of the packet. Address 0 holds the header, addresses 1..L hold the message and address L+1 holds the checksum.
- R9: After reset, `pkt_done`, `pkt_ok`, `pkt_hdr` and `pkt_len` are 0 and every buffer address reads 0.
- R10: Cycles with `byte_vld` low neither advance the packet nor produce a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| sop | input | 1 | New preamble seen; discard partial packet |
| abort | input | 1 | Framing lost; discard partial packet |
| pkt_done | output | 1 | One-cycle pulse when a packet completes |
| pkt_ok | output | 1 | Checksum of the last completed packet matched |
| pkt_hdr | output | 8 | Header of the last completed packet |
| pkt_len | output | 5 | Message length of the last completed packet |
| rd_addr | input | 5 | Buffer read address |
| rd_data | output | 8 | Buffer byte at `rd_addr` (combinational) |

## Verification
A wrong byte count or a header latched at the wrong time shows up as a completion pulse that arrives too early, too late or not at all. The cycle-accurate model catches that on the very cycle the pulse was due. A stale or corrupted XOR accumulator flips `pkt_ok` on the next completion, and a missed discard is seen as a completion reporting the wrong header. Every header range boundary, back-to-back packets, idle gaps, and discards that coincide with a byte are driven, and the buffer is read out in full after completions.

// File: rtl/pkt_asm_pkg.sv
// Package: shared widths and limits of the packet assembler.
// Assumes 8-bit bytes and the fixed header-to-length rule of this block.
package pkt_asm_pkg;
    parameter int BYTE_W  = 8;
    parameter int LEN_W   = 5;
    parameter int MAX_MSG = 27;
    parameter int MAX_PKT = MAX_MSG + 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LEN_W-1:0]  mlen_t;
endpackage

// File: rtl/pkt_len_decode.sv
// Module: maps a header byte to its message length.
// Purely combinational; four header ranges, each with its own step size.
module pkt_len_decode
    import pkt_asm_pkg::*;
(
    input  byte_t hdr,
    output mlen_t mlen
);
    byte_t off;

    // Piecewise length rule: choose the range, then scale the offset into it.
    always_comb begin
        off  = '0;
        mlen = '0;
        if (hdr < 8'h20) begin
            mlen = 5'd1;
        end else if (hdr < 8'h80) begin
            off  = hdr - 8'h20;
            mlen = 5'd2 + {1'b0, off[7:4]};
        end else if (hdr < 8'hE0) begin
            off  = hdr - 8'h80;
            mlen = 5'd8 + off[7:3];
        end else begin
            off  = hdr - 8'hE0;
            mlen = 5'd20 + {2'b00, off[4:2]};
        end
    end
endmodule

// File: rtl/pkt_xor_accum.sv
// Module: running XOR of the bytes seen so far in a packet.
// load starts a new sum from din; add folds din into the sum; load wins.
module pkt_xor_accum
    import pkt_asm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  add,
    input  byte_t din,
    output byte_t acc
);
    // Accumulator register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (load) acc <= din;
        else if (add)  acc <= acc ^ din;
    end
endmodule

// File: rtl/pkt_byte_buffer.sv
// Module: packet byte store, one write port and a combinational read port.
// Assumes DEPTH is a power of two, so every read address is in range.
module pkt_byte_buffer
    import pkt_asm_pkg::*;
#(
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    byte_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // One storage entry: cleared by reset, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                         mem[i] <= '0;
            else if (we && (int'(waddr) == i))  mem[i] <= wdata;
        end
    end

    // Combinational read of the addressed entry.
    assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_assembler.sv
// Module: top of the packet assembler.
// Counts accepted bytes, latches the header and its decoded length, and
// reports completion with the checksum verdict. abort and sop both discard
// the partial packet, and a byte presented alongside either one is dropped.
module pkt_assembler
    import pkt_asm_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int ADDR_W   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              sop,
    input  logic              abort,
    output logic              pkt_done,
    output logic              pkt_ok,
    output logic [7:0]        pkt_hdr,
    output logic [4:0]        pkt_len,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic  [LEN_W-1:0] cnt;
    byte_t             hdr_q;
    mlen_t             len_q;
    mlen_t             len_dec;
    byte_t             xor_acc;
    logic              accept, first, last;

    // Classify the current byte: taken or not, header, or closing byte.
    always_comb begin
        accept = byte_vld && !sop && !abort;
        first  = accept && (cnt == '0);
        last   = accept && (cnt != '0) && (int'(cnt) == int'(len_q) + 1);
    end

    pkt_len_decode u_dec (
        .hdr  (byte_data),
        .mlen (len_dec)
    );

    pkt_xor_accum u_xor (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (first),
        .add   (accept && !first && !last),
        .din   (byte_data),
        .acc   (xor_acc)
    );

    pkt_byte_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept),
        .waddr (ADDR_W'(cnt)),
        .wdata (byte_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Byte counter: cleared by a discard or a completion, else advanced.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (sop || abort)   cnt <= '0;
        else if (last)           cnt <= '0;
        else if (accept)         cnt <= cnt + 1'b1;
    end

    // Header and decoded length, captured on the first byte of a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            len_q <= '0;
        end else if (first) begin
            hdr_q <= byte_data;
            len_q <= len_dec;
        end
    end

    // Completion outputs: pulse plus a verdict and identity that hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_done <= 1'b0;
            pkt_ok   <= 1'b0;
            pkt_hdr  <= '0;
            pkt_len  <= '0;
        end else begin
            pkt_done <= last;
            if (last) begin
                pkt_ok  <= (byte_data == xor_acc);
                pkt_hdr <= hdr_q;
                pkt_len <= len_q;
            end
        end
    end
endmodule

// Checker: temporal properties of the assembler, seen at its ports.
module pkt_assembler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       sop,
    input logic       abort,
    input logic       pkt_done,
    input logic       pkt_ok,
    input logic [7:0] pkt_hdr,
    input logic [4:0] pkt_len
);
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |-> ($stable(pkt_hdr) && $stable(pkt_len)));

    assert_ok_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |-> $stable(pkt_ok));

    assert_len_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len >= 5'd1 && pkt_len <= 5'd27));

    assert_abort_kills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !pkt_done);

    assert_sop_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sop |=> !pkt_done);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> !pkt_done);
endmodule

bind pkt_assembler pkt_assembler_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .sop      (sop),
    .abort    (abort),
    .pkt_done (pkt_done),
    .pkt_ok   (pkt_ok),
    .pkt_hdr  (pkt_hdr),
    .pkt_len  (pkt_len)
);

// File: tb/pkt_assembler_tb.sv
// Bench: behavioural queue model stepped every clock and compared with the DUT.
module pkt_assembler_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       sop = 1'b0;
    logic       abort = 1'b0;
    logic       pkt_done, pkt_ok;
    logic [7:0] pkt_hdr;
    logic [4:0] pkt_len;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;

    // Model state
    int q[$];
    int last_pkt[$];
    int e_done = 0, e_ok = 0, e_hdr = 0, e_len = 0;

    always #4 clk = ~clk;

    pkt_assembler dut_i (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .sop(sop), .abort(abort), .pkt_done(pkt_done), .pkt_ok(pkt_ok),
        .pkt_hdr(pkt_hdr), .pkt_len(pkt_len), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int mlen(int h);
        if (h < 32)       return 1;
        else if (h < 128) return 2 + (h - 32) / 16;
        else if (h < 224) return 8 + (h - 128) / 8;
        else              return 20 + (h - 224) / 4;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic step(input logic v, input int d, input logic s, input logic a);
        int x;
        byte_vld = v; byte_data = 8'(d); sop = s; abort = a;
        e_done = 0;
        if (s || a) q.delete();
        else if (v) begin
            q.push_back(d);
            if (q.size() == mlen(q[0]) + 2) begin
                x = 0;
                for (int i = 0; i < q.size() - 1; i++) x = x ^ q[i];
                e_done = 1;
                e_ok   = (x == q[q.size()-1]) ? 1 : 0;
                e_hdr  = q[0];
                e_len  = mlen(q[0]);
                last_pkt = q;
                q.delete();
            end
        end
        @(posedge clk);
        @(negedge clk);
        byte_vld = 1'b0; sop = 1'b0; abort = 1'b0;
        chk("R3 pkt_done", int'(pkt_done), e_done);
        chk("R4 pkt_ok", int'(pkt_ok), e_ok);
        chk("R3 pkt_hdr", int'(pkt_hdr), e_hdr);
        chk(e_hdr >= 128 ? "R2 pkt_len" : "R1 pkt_len", int'(pkt_len), e_len);
    endtask

    task automatic check_buffer();
        for (int i = 0; i < last_pkt.size(); i++) begin
            rd_addr = 5'(i);
            #1;
            chk("R8 buffer", int'(rd_data), last_pkt[i]);
        end
        @(negedge clk);
    endtask

    task automatic send_packet(input int hdr, input bit bad, input int gap);
        int n, x, b;
        n = mlen(hdr);
        x = hdr;
        step(1'b1, hdr, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < gap; g++) step(1'b0, 8'hEE, 1'b0, 1'b0);
            b = (hdr * 7 + i * 29 + 3) & 255;
            x = x ^ b;
            step(1'b1, b, 1'b0, 1'b0);
        end
        step(1'b1, bad ? (x ^ 8'h5A) : x, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 pkt_done", int'(pkt_done), 0);
        chk("R9 pkt_ok", int'(pkt_ok), 0);
        chk("R9 pkt_hdr", int'(pkt_hdr), 0);
        chk("R9 pkt_len", int'(pkt_len), 0);
        for (int i = 0; i < 32; i += 7) begin
            rd_addr = 5'(i); #1;
            chk("R9 buffer", int'(rd_data), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 0, 1'b0, 1'b0);

        // R1 / R4 / R8: short packet, good then bad checksum
        send_packet(8'h01, 1'b0, 0); check_buffer();
        send_packet(8'h05, 1'b1, 0); check_buffer();
        // R1 / R10: idle gaps inside packets
        send_packet(8'h1F, 1'b0, 2);
        send_packet(8'h20, 1'b0, 1);
        send_packet(8'h30, 1'b1, 0);
        send_packet(8'h7F, 1'b0, 0); check_buffer();
        // R2: upper ranges and the edges between them
        send_packet(8'h80, 1'b0, 0);
        send_packet(8'hDF, 1'b0, 0); check_buffer();
        send_packet(8'hE0, 1'b1, 0);
        send_packet(8'hFF, 1'b0, 0); check_buffer();
        // R5: back to back, no idle cycles
        send_packet(8'h10, 1'b0, 0);
        send_packet(8'h85, 1'b0, 0);
        send_packet(8'h00, 1'b0, 0);

        // R6: abort mid packet, then a fresh packet
        step(1'b1, 8'h90, 1'b0, 1'b0);
        step(1'b1, 8'h11, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b1);
        send_packet(8'h02, 1'b0, 0); check_buffer();
        // R6: abort coinciding with a byte drops that byte
        step(1'b1, 8'h40, 1'b0, 1'b0);
        step(1'b1, 8'h03, 1'b0, 1'b1);
        send_packet(8'h03, 1'b0, 0);
        // R7: sop mid packet and sop coinciding with a byte
        step(1'b1, 8'hF0, 1'b0, 1'b0);
        step(1'b1, 8'h22, 1'b0, 1'b0);
        step(1'b1, 8'h33, 1'b1, 1'b0);
        send_packet(8'h51, 1'b0, 0); check_buffer();
        step(1'b0, 0, 1'b1, 1'b0);
        send_packet(8'h71, 1'b1, 1);

        repeat (3) step(1'b0, 0, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule